// File: doc/BRIEF.md
# Strip Alpha Compositing Buffer

This block builds a video frame one horizontal strip at a time. Image layers for a strip arrive one after another, nearest layer first. Each input beat carries four adjacent RGBA pixels and their position in the strip. Every pixel is blended into the strip store with the "under" operator. A per-pixel 8-bit coverage value tracks how opaque the stack is so far. Colour is held in two banks. One bank takes the layers for the current strip while the other is streamed out, left to right and top to bottom, to the video back end.

The producer marks the first beat of a strip with a start flag. That beat clears the compositing bank and the coverage store. The producer marks the last beat of the strip with an end flag. After that beat the input stalls until the readout side has sent its last pixel, and then the banks swap. The strip width and the number of lines are parameters. Their defaults are scaled down from the full-size 1344 x 32 strip.

Top module: `strip_compositor`

## Requirements
- R1: A beat holds four pixels. Pixel k sits in `in_pix_i[k*32 +: 32]`, laid out as R in [31:24], G in [23:16], B in [15:8] and alpha in [7:0]. Pixel k lands at strip entry `line*LINE_W + x + k`, and `x` is a multiple of 4.
- R2: With rnd(v) = round(v/255), weight w = rnd((255 - A) * a), where A is the stored coverage and a is the layer alpha. Each stored channel becomes min(255, C + rnd(w * c)).
- R3: The stored coverage becomes A + w, so it never decreases.
- R4: A layer pixel with alpha 0 leaves the stored colour and coverage unchanged. An entry whose coverage is already 255 ignores every later layer.
- R5: The beat flagged start-of-strip treats the whole compositing bank and the coverage store as zero. Entries that no layer of that strip writes read out as zero.
- R6: After the end-of-strip beat is accepted, `in_ready_o` is low. The banks swap on the first cycle in which the readout is idle. Readout of the new strip begins the cycle after the swap, and `in_ready_o` returns high in that same cycle.
- R7: Readout emits entries in raster order and sets `out_last_o` only on the final entry. A stalled output holds its pixel.
- R8: After reset, `in_ready_o` is high and `out_valid_o` is low.
- R9: A strip can be composited completely while the previous strip waits in the other bank. The waiting strip reads out unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| in_valid_i | input | 1 | input beat valid |
| in_ready_o | output | 1 | input beat accepted when high |
| in_sos_i | input | 1 | beat is the first of a strip |
| in_eos_i | input | 1 | beat is the last of a strip |
| in_line_i | input | LW | line within the strip |
| in_x_i | input | XW | x of the beat's first pixel |
| in_pix_i | input | 4*32 | four RGBA layer pixels |
| out_valid_o | output | 1 | output pixel valid |
| out_ready_i | input | 1 | output consumer ready |
| out_rgb_o | output | 24 | composited colour, R in [23:16] |
| out_last_o | output | 1 | final pixel of the strip |

## Verification
A single layer over a cleared bank isolates the blend path's scaling by alpha. A stack of three layers, which mixes fully transparent and fully opaque pixels, exposes the weight term, the coverage update and the opaque cut-off. None of those would show with one layer. A strip that writes a single beat tells true clearing apart from stale data left by a strip two swaps earlier. Composing a second strip while the first is held unread, with a stalling consumer, separates the two banks. It also shows that the swap waits for the readout.

// File: rtl/strip_comp_pkg.sv
package strip_comp_pkg;
  localparam int unsigned CH_W = 8;
  typedef logic [3*CH_W-1:0] rgb_t;

  // round(x/255) for x <= 255*255
  function automatic logic [CH_W-1:0] div255_round(input logic [15:0] x);
    logic [16:0] s;
    s = 17'(x) + 17'd128;
    return CH_W'((s + (s >> 8)) >> 8);
  endfunction
endpackage

// File: rtl/strip_blend_unit.sv
module strip_blend_unit
  import strip_comp_pkg::*;
(
  input  logic [31:0]     lay_i,
  input  rgb_t            col_i,
  input  logic [CH_W-1:0] alp_i,
  output rgb_t            col_o,
  output logic [CH_W-1:0] alp_o
);
  logic [CH_W-1:0] lay_a, weight;
  logic [15:0]     prod_w;

  assign lay_a  = lay_i[CH_W-1:0];
  assign prod_w = 16'(8'hFF - alp_i) * 16'(lay_a);
  assign weight = div255_round(prod_w);
  assign alp_o  = alp_i + weight;

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    logic [15:0] prod;
    logic [8:0]  sum;
    assign prod = 16'(weight) * 16'(lay_i[(ch+1)*CH_W +: CH_W]);
    assign sum  = 9'(col_i[ch*CH_W +: CH_W]) + 9'(div255_round(prod));
    assign col_o[ch*CH_W +: CH_W] = sum[8] ? 8'hFF : sum[7:0];
  end

  always_comb begin
    p_alpha_grow_r3: assert (alp_o >= alp_i);
    if (lay_a == '0 || alp_i == 8'hFF)
      p_no_effect_r4: assert (col_o == col_i && alp_o == alp_i);
  end
endmodule

// File: rtl/strip_bank_ctrl.sv
module strip_bank_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic eos_i,
  input  logic rd_busy_i,
  output logic comp_bank_o,
  output logic in_ready_o,
  output logic swap_o
);
  logic done_q;

  assign swap_o     = done_q && !rd_busy_i;
  assign in_ready_o = !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q      <= 1'b0;
      comp_bank_o <= 1'b0;
    end else if (swap_o) begin
      done_q      <= 1'b0;
      comp_bank_o <= ~comp_bank_o;
    end else if (acc_i && eos_i) begin
      done_q <= 1'b1;
    end
  end

  p_wait_readout_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && rd_busy_i |=> done_q);
endmodule

// File: rtl/strip_readout.sv
module strip_readout #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [AW-1:0] idx_o,
  output logic          last_o
);
  logic fire;

  assign last_o = valid_o && (idx_o == AW'(DEPTH - 1));
  assign fire   = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else if (start_i) begin
      valid_o <= 1'b1;
      idx_o   <= '0;
    end else if (fire) begin
      if (last_o) valid_o <= 1'b0;
      else        idx_o   <= idx_o + 1'b1;
    end
  end

  p_start_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !valid_o);
  p_raster_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !last_o |=> valid_o && idx_o == $past(idx_o) + 1'b1);
  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(idx_o));
endmodule

// File: rtl/strip_compositor.sv
module strip_compositor
  import strip_comp_pkg::*;
#(
  parameter int unsigned LINE_W      = 16,
  parameter int unsigned STRIP_LINES = 4,
  parameter int unsigned BEAT_PIX    = 4,
  localparam int unsigned DEPTH = LINE_W * STRIP_LINES,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned XW    = $clog2(LINE_W),
  localparam int unsigned LW    = (STRIP_LINES > 1) ? $clog2(STRIP_LINES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic                  in_sos_i,
  input  logic                  in_eos_i,
  input  logic [LW-1:0]         in_line_i,
  input  logic [XW-1:0]         in_x_i,
  input  logic [BEAT_PIX*32-1:0] in_pix_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [23:0]           out_rgb_o,
  output logic                  out_last_o
);
  rgb_t            col_q [2][DEPTH];
  logic [CH_W-1:0] alp_q [DEPTH];

  logic            comp_bank, swap, acc;
  logic [AW-1:0]   base, rd_idx;
  logic [AW-1:0]   addr  [BEAT_PIX];
  rgb_t            old_c [BEAT_PIX];
  rgb_t            new_c [BEAT_PIX];
  logic [CH_W-1:0] old_a [BEAT_PIX];
  logic [CH_W-1:0] new_a [BEAT_PIX];

  assign acc  = in_valid_i && in_ready_o;
  assign base = AW'(in_line_i) * AW'(LINE_W) + AW'(in_x_i);

  for (genvar k = 0; k < BEAT_PIX; k++) begin : g_lane
    assign addr[k]  = base + AW'(k);
    assign old_c[k] = in_sos_i ? '0 : col_q[comp_bank][addr[k]];
    assign old_a[k] = in_sos_i ? '0 : alp_q[addr[k]];
    strip_blend_unit u_blend (
      .lay_i (in_pix_i[k*32 +: 32]),
      .col_i (old_c[k]),
      .alp_i (old_a[k]),
      .col_o (new_c[k]),
      .alp_o (new_a[k])
    );
  end

  strip_bank_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .eos_i       (in_eos_i),
    .rd_busy_i   (out_valid_o),
    .comp_bank_o (comp_bank),
    .in_ready_o  (in_ready_o),
    .swap_o      (swap)
  );

  strip_readout #(.DEPTH(DEPTH)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (swap),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .idx_o   (rd_idx),
    .last_o  (out_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        col_q[0][i] <= '0;
        col_q[1][i] <= '0;
        alp_q[i]    <= '0;
      end
    end else if (acc) begin
      if (in_sos_i) begin
        for (int i = 0; i < DEPTH; i++) begin
          col_q[comp_bank][i] <= '0;
          alp_q[i]            <= '0;
        end
      end
      for (int k = 0; k < BEAT_PIX; k++) begin
        col_q[comp_bank][addr[k]] <= new_c[k];
        alp_q[addr[k]]            <= new_a[k];
      end
    end
  end

  // readout side always faces the bank not being composited
  assign out_rgb_o = col_q[~comp_bank][rd_idx];

  p_beat_in_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (int'(in_x_i) % BEAT_PIX == 0) &&
                   (int'(in_x_i) + BEAT_PIX <= LINE_W) &&
                   (int'(in_line_i) < STRIP_LINES));
  p_readout_isolated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_rgb_o));
  p_valid_after_swap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |=> out_valid_o && in_ready_o);
endmodule

// File: tb/sim_strip_compositor.sv
module sim_strip_compositor;
  localparam int W = 16, L = 4, D = W * L, BP = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni, in_valid_i, in_ready_o, in_sos_i, in_eos_i;
  logic [1:0]    in_line_i;
  logic [3:0]    in_x_i;
  logic [127:0]  in_pix_i;
  logic          out_valid_o, out_ready_i, out_last_o;
  logic [23:0]   out_rgb_o;

  strip_compositor #(.LINE_W(W), .STRIP_LINES(L), .BEAT_PIX(BP)) u0 (.*, .clk_i(clk));

  int n_chk = 0, n_bad = 0;
  logic [23:0] cur_c [D];
  logic [7:0]  cur_a [D];
  logic [23:0] snap  [2][D];
  int snap_wr = 0, snap_rd = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int rnd255(int v);
    return (v + 127) / 255;
  endfunction

  function automatic logic [31:0] gen_pix(int s, int i);
    logic [7:0] a;
    case ((i + s) % 5)
      0: a = 8'd0;
      1: a = 8'd255;
      default: a = 8'((s * 53 + i * 29 + 7) & 255);
    endcase
    return {8'((s * 37 + i * 11) & 255), 8'((s * 91 + i * 5 + 3) & 255),
            8'((s * 17 + i * 73 + 9) & 255), a};
  endfunction

  task automatic model_beat(bit sos, int line, int x, logic [127:0] pix);
    if (sos) for (int i = 0; i < D; i++) begin cur_c[i] = '0; cur_a[i] = '0; end
    for (int k = 0; k < BP; k++) begin
      int idx = line * W + x + k;
      int a = int'(pix[k*32 +: 8]);
      int w = rnd255((255 - int'(cur_a[idx])) * a);
      for (int ch = 0; ch < 3; ch++) begin
        int c = int'(cur_c[idx][ch*8 +: 8]) + rnd255(w * int'(pix[k*32 + (ch+1)*8 +: 8]));
        cur_c[idx][ch*8 +: 8] = 8'((c > 255) ? 255 : c);
      end
      cur_a[idx] = 8'(int'(cur_a[idx]) + w);
    end
  endtask

  task automatic send(bit sos, bit eos, int line, int x, logic [127:0] pix);
    @(negedge clk);
    in_valid_i = 1'b1; in_sos_i = sos; in_eos_i = eos;
    in_line_i = 2'(line); in_x_i = 4'(x); in_pix_i = pix;
    while (!in_ready_o) @(negedge clk);
    @(posedge clk);
    model_beat(sos, line, x, pix);
    if (eos) begin
      for (int i = 0; i < D; i++) snap[snap_wr][i] = cur_c[i];
      snap_wr ^= 1;
    end
    #1;
    in_valid_i = 1'b0; in_sos_i = 1'b0; in_eos_i = 1'b0;
  endtask

  task automatic send_layer(int seed, bit sos, bit eos);
    for (int ln = 0; ln < L; ln++)
      for (int x = 0; x < W; x += BP) begin
        logic [127:0] p;
        for (int k = 0; k < BP; k++) p[k*32 +: 32] = gen_pix(seed, ln * W + x + k);
        send(sos && ln == 0 && x == 0, eos && ln == L - 1 && x == W - BP, ln, x, p);
      end
  endtask

  task automatic drain(string tag, bit stall);
    int i = 0, cyc = 0;
    while (i < D) begin
      @(negedge clk);
      out_ready_i = stall ? (cyc % 3 != 2) : 1'b1;
      cyc++;
      if (out_valid_o && out_ready_i) begin
        chk($sformatf("%s pixel %0d rgb", tag, i), 32'(out_rgb_o), 32'(snap[snap_rd][i]));
        chk($sformatf("R7 pixel %0d last", i), 32'(out_last_o), 32'(i == D - 1));
        i++;
      end
    end
    snap_rd ^= 1;
    @(negedge clk);
    out_ready_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R8 in_ready after reset", 32'(in_ready_o), 32'd1);
    chk("R8 out_valid after reset", 32'(out_valid_o), 32'd0);
  endtask

  task automatic t_single_layer;
    send_layer(1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R6 in_ready low after eos", 32'(in_ready_o), 32'd0);
    chk("R6 no output before swap", 32'(out_valid_o), 32'd0);
    @(negedge clk);
    chk("R6 output after swap", 32'(out_valid_o), 32'd1);
    chk("R6 in_ready back after swap", 32'(in_ready_o), 32'd1);
    drain("R1 R2 single layer", 1'b0);
  endtask

  task automatic t_multi_layer;
    send_layer(2, 1'b1, 1'b0);
    send_layer(3, 1'b0, 1'b0);
    send_layer(4, 1'b0, 1'b1);
    drain("R3 R4 three layers", 1'b1);
  endtask

  task automatic t_clear;
    logic [127:0] p;
    for (int k = 0; k < BP; k++) p[k*32 +: 32] = gen_pix(6, k + 2);
    send(1'b1, 1'b1, 1, 4, p);
    drain("R5 partial strip", 1'b0);
  endtask

  task automatic t_double_buffer;
    send_layer(7, 1'b1, 1'b0);
    send_layer(8, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R9 in_ready while strip held", 32'(in_ready_o), 32'd1);
    chk("R9 held strip valid", 32'(out_valid_o), 32'd1);
    send_layer(9, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R6 in_ready low while readout busy", 32'(in_ready_o), 32'd0);
    chk("R6 readout still pending", 32'(out_valid_o), 32'd1);
    drain("R9 held strip", 1'b1);
    drain("R9 second strip", 1'b0);
    @(negedge clk);
    chk("R6 in_ready after both strips", 32'(in_ready_o), 32'd1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_ni = 1'b0; in_valid_i = 1'b0; in_sos_i = 1'b0; in_eos_i = 1'b0;
    in_line_i = '0; in_x_i = '0; in_pix_i = '0; out_ready_i = 1'b0;
    for (int i = 0; i < D; i++) begin cur_c[i] = '0; cur_a[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_single_layer();
    t_multi_layer();
    t_clear();
    t_double_buffer();
    summary();
  end
endmodule